// File: doc/BRIEF.md
# Width-Segmented Two-Way Data Cache

This block is a small write-back data cache that serves 16-bit and 32-bit loads and stores through one processor port. It has two ways. Each 64-bit line is split into four 16-bit segments. A 32-bit access uses two adjacent segments, and a 16-bit access uses exactly one. The data array enables only the segments that hold the requested value, so a narrow access switches half as much of the array as a wide one. Set selection, tag matching, replacement and dirty tracking work the same way for both widths.

The processor presents a request and holds it until `resp_ready` is high. A hit or an alignment error completes in the same cycle that it is presented. On a miss, the cache first writes back a dirty victim line as one whole line over the backing port. It then fetches the new line and finishes the original request as a hit. The address is split into a tag, a 4-bit set index (bits 6:3) and a 3-bit byte offset (bits 2:0). Data is little-endian: halfword k of a line occupies line bits 16k+15:16k.

Top module: `dual_width_dcache`

## Requirements
- R1: A load hit returns data in the same cycle. A wide load (`req_wide`=1) returns line bits 31:0 when offset bit 2 is 0 and bits 63:32 when it is 1. A narrow load returns halfword k = offset[2:1] in bits 15:0, with bits 31:16 set to zero.
- R2: A store hit writes only the addressed segments. A narrow store writes `req_wdata[15:0]` into halfword k. A wide store writes `req_wdata` into halfwords 2j and 2j+1, where j = offset bit 2. All other halfwords of the line keep their values.
- R3: Misalignment is a narrow access with address bit 0 set, or a wide access with address bits 1:0 not both zero. A misaligned access completes at once with `resp_err`=1. It causes no memory traffic, enables no segment and changes no cached data.
- R4: `seg_en` bit 4w+k enables segment k of way w. During a successful hit it has exactly the bits of the accessed segments set: one bit for a narrow access and two bits (k = 0,1 or k = 2,3) for a wide access. It is zero whenever `resp_err` is high.
- R5: Each set keeps one LRU bit. The victim is the lowest-numbered invalid way if there is one, otherwise the way named by the LRU bit. A hit to way w, or a fill into way w, makes the other way least recently used.
- R6: A store of either width marks its line dirty. On a miss whose victim is valid and dirty, the whole victim line is written to line address {victim tag, index} before the new line is fetched. A clean or invalid victim causes no write-back.
- R7: While `mem_req` is high without `mem_ack`, `mem_req`, `mem_we` and `mem_addr` stay stable. Each acknowledged transfer moves exactly one 64-bit line.
- R8: After reset all lines are invalid, `resp_ready` and `mem_req` are low, and the first access to any address misses.
- R9: A hit completes in the cycle it is presented, without backing-port traffic. A miss completes after exactly one fill, plus one write-back if the victim was dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until resp_ready |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data (narrow stores use bits 15:0) |
| resp_ready | output | 1 | Request completes this cycle |
| resp_err | output | 1 | Completed request was misaligned |
| resp_rdata | output | 32 | Load data |
| seg_en | output | 8 | Per-way, per-segment data array enables |
| mem_req | output | 1 | Backing transfer requested |
| mem_we | output | 1 | 1 = write-back, 0 = fill |
| mem_addr | output | ADDR_W-3 | Line address of the transfer |
| mem_wline | output | 64 | Write-back line data |
| mem_rline | input | 64 | Fill line data, valid with mem_ack |
| mem_ack | input | 1 | Transfer completes this cycle |

## Verification
The bench sweeps every set, three conflicting tags, every byte offset, both widths and both directions, twice. A reference model in the bench predicts hits, victims, write-backs and data. If the halfword or word selection were wrong, loads would return a neighbouring segment. If stores wrote too wide a range, later loads of untouched halfwords would change. If a misaligned store leaked into the array, the shadow image would no longer match later loads. A wrong LRU update or a wrong victim choice shows up as an unexpected fill or write-back count, or as an enable on the wrong way. A write-back that went to the new tag's address, or that left out dirty data, shows up as a mismatch in the written line or its address.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  localparam int SEG_W  = 16;
  localparam int SEGS   = 4;
  localparam int LINE_W = SEG_W * SEGS;

  typedef enum logic [1:0] {ST_IDLE, ST_WBACK, ST_FILL} dwc_state_e;

  // segments covered by an access; off_hi is byte offset bits 2:1
  function automatic logic [SEGS-1:0] seg_mask(input logic wide, input logic [1:0] off_hi);
    if (wide) return off_hi[1] ? 4'b1100 : 4'b0011;
    return 4'b0001 << off_hi;
  endfunction

  function automatic logic misaligned(input logic wide, input logic [1:0] off_lo);
    return wide ? (off_lo != 2'b00) : off_lo[0];
  endfunction

  function automatic logic [31:0] pick(input logic [LINE_W-1:0] line, input logic wide,
                                       input logic [1:0] off_hi);
    if (wide) return off_hi[1] ? line[63:32] : line[31:0];
    return {16'h0, line[off_hi*SEG_W +: SEG_W]};
  endfunction

  // replicate store data so any enabled segment sees the right bits
  function automatic logic [LINE_W-1:0] spread(input logic wide, input logic [31:0] d);
    return wide ? {d, d} : {4{d[15:0]}};
  endfunction
endpackage

// File: rtl/dwc_tag_store.sv
module dwc_tag_store #(
  parameter int SETS  = 16,
  parameter int TAG_W = 9,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      idx,
  output logic [1:0][TAG_W-1:0] rd_tag,
  output logic [1:0]            rd_valid,
  output logic [1:0]            rd_dirty,
  output logic                  rd_lru,
  input  logic                  touch_en,
  input  logic                  touch_way,
  input  logic                  touch_dirty,
  input  logic                  fill_en,
  input  logic                  fill_way,
  input  logic [TAG_W-1:0]      fill_tag
);
  logic [TAG_W-1:0]      tag_q [SETS][2];
  logic [SETS-1:0][1:0]  valid_q;
  logic [SETS-1:0][1:0]  dirty_q;
  logic [SETS-1:0]       lru_q;

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx][fill_way] <= fill_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      lru_q   <= '0;
    end else if (fill_en) begin
      valid_q[idx][fill_way] <= 1'b1;
      dirty_q[idx][fill_way] <= 1'b0;
      lru_q[idx]             <= ~fill_way;
    end else if (touch_en) begin
      lru_q[idx] <= ~touch_way;
      if (touch_dirty) dirty_q[idx][touch_way] <= 1'b1;
    end
  end

  assign rd_tag[0] = tag_q[idx][0];
  assign rd_tag[1] = tag_q[idx][1];
  assign rd_valid  = valid_q[idx];
  assign rd_dirty  = dirty_q[idx];
  assign rd_lru    = lru_q[idx];
endmodule

// File: rtl/dwc_data_array.sv
module dwc_data_array
  import dwc_pkg::*;
#(
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                   clk,
  input  logic [IDX_W-1:0]       idx,
  input  logic                   way,
  input  logic [SEGS-1:0]        seg_we,
  input  logic [LINE_W-1:0]      wline,
  output logic [1:0][LINE_W-1:0] rline
);
  logic [LINE_W-1:0] mem_q [SETS][2];

  for (genvar k = 0; k < SEGS; k++) begin : g_seg
    always_ff @(posedge clk) begin
      if (seg_we[k]) mem_q[idx][way][k*SEG_W +: SEG_W] <= wline[k*SEG_W +: SEG_W];
    end
  end

  assign rline[0] = mem_q[idx][0];
  assign rline[1] = mem_q[idx][1];
endmodule

// File: rtl/dwc_ctrl.sv
module dwc_ctrl
  import dwc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       misal,
  input  logic       hit,
  input  logic       victim_dirty,
  input  logic       mem_ack,
  output dwc_state_e state,
  output logic       resp_ready,
  output logic       acc_ok,
  output logic       miss_start,
  output logic       fill_done,
  output logic       mem_req,
  output logic       mem_we
);
  dwc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (miss_start) state_d = victim_dirty ? ST_WBACK : ST_FILL;
      ST_WBACK: if (mem_ack) state_d = ST_FILL;
      ST_FILL:  if (mem_ack) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state      = state_q;
  assign resp_ready = (state_q == ST_IDLE) && req_valid && (misal || hit);
  assign acc_ok     = (state_q == ST_IDLE) && req_valid && !misal && hit;
  assign miss_start = (state_q == ST_IDLE) && req_valid && !misal && !hit;
  assign fill_done  = (state_q == ST_FILL) && mem_ack;
  assign mem_req    = (state_q != ST_IDLE);
  assign mem_we     = (state_q == ST_WBACK);
endmodule

// File: rtl/dual_width_dcache.sv
module dual_width_dcache
  import dwc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SETS   = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = 3,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int LA_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              resp_ready,
  output logic              resp_err,
  output logic [31:0]       resp_rdata,
  output logic [2*SEGS-1:0] seg_en,
  output logic              mem_req,
  output logic              mem_we,
  output logic [LA_W-1:0]   mem_addr,
  output logic [LINE_W-1:0] mem_wline,
  input  logic [LINE_W-1:0] mem_rline,
  input  logic              mem_ack
);
  logic [IDX_W-1:0]      idx;
  logic [TAG_W-1:0]      tag;
  logic [1:0][TAG_W-1:0] rd_tag;
  logic [1:0]            rd_valid, rd_dirty;
  logic                  rd_lru;
  logic [1:0][LINE_W-1:0] rline;
  logic [1:0]            way_hit;
  logic                  hit, hit_way, misal;
  logic                  victim, victim_q, victim_dirty;
  logic                  acc_ok, miss_start, fill_done;
  logic [SEGS-1:0]       acc_mask, arr_we;
  logic [LINE_W-1:0]     arr_wline;
  logic                  arr_way;
  dwc_state_e            state;

  assign idx   = req_addr[OFF_W +: IDX_W];
  assign tag   = req_addr[ADDR_W-1 -: TAG_W];
  assign misal = misaligned(req_wide, req_addr[1:0]);

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign way_hit[w] = rd_valid[w] && (rd_tag[w] == tag);
  end
  assign hit     = |way_hit;
  assign hit_way = way_hit[1];

  // invalid way first (way 0 before way 1), otherwise the LRU way
  assign victim       = !rd_valid[0] ? 1'b0 : (!rd_valid[1] ? 1'b1 : rd_lru);
  assign victim_dirty = rd_valid[victim] && rd_dirty[victim];

  always_ff @(posedge clk) begin
    if (!rst_n)          victim_q <= 1'b0;
    else if (miss_start) victim_q <= victim;
  end

  dwc_ctrl u_ctrl (
    .clk, .rst_n, .req_valid, .misal, .hit, .victim_dirty, .mem_ack,
    .state, .resp_ready, .acc_ok, .miss_start, .fill_done, .mem_req, .mem_we
  );

  dwc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk, .rst_n, .idx, .rd_tag, .rd_valid, .rd_dirty, .rd_lru,
    .touch_en(acc_ok), .touch_way(hit_way), .touch_dirty(req_write),
    .fill_en(fill_done), .fill_way(victim_q), .fill_tag(tag)
  );

  assign acc_mask  = seg_mask(req_wide, req_addr[2:1]);
  assign arr_we    = fill_done ? '1 : ((acc_ok && req_write) ? acc_mask : '0);
  assign arr_wline = fill_done ? mem_rline : spread(req_wide, req_wdata);
  assign arr_way   = fill_done ? victim_q : hit_way;

  dwc_data_array #(.SETS(SETS)) u_data (
    .clk, .idx, .way(arr_way), .seg_we(arr_we), .wline(arr_wline), .rline
  );

  logic [SEGS-1:0] en_mask;
  logic            en_way;
  always_comb begin
    en_mask = '0;
    en_way  = hit_way;
    if (acc_ok) begin
      en_mask = acc_mask;
    end else if (mem_ack && (state != ST_IDLE)) begin
      en_mask = '1;
      en_way  = victim_q;
    end
  end
  assign seg_en = en_way ? {en_mask, {SEGS{1'b0}}} : {{SEGS{1'b0}}, en_mask};

  assign resp_err   = resp_ready && misal;
  assign resp_rdata = pick(rline[hit_way], req_wide, req_addr[2:1]);
  assign mem_addr   = (state == ST_WBACK) ? {rd_tag[victim_q], idx} : {tag, idx};
  assign mem_wline  = rline[victim_q];
endmodule

// File: rtl/dwc_checker.sv
module dwc_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_wide,
  input logic [ADDR_W-1:0] req_addr,
  input logic              resp_ready,
  input logic              resp_err,
  input logic [7:0]        seg_en,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-4:0] mem_addr,
  input logic              mem_ack
);
  logic bad_align;
  assign bad_align = req_wide ? (req_addr[1] | req_addr[0]) : req_addr[0];

  AST_ALIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_ready && bad_align) |-> resp_err); // R3
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> (seg_en == 8'h00 && !mem_req)); // R3
  AST_NARROW_ONE_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_ready && !resp_err && !req_wide) |-> $countones(seg_en) == 1); // R4
  AST_WIDE_TWO_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_ready && !resp_err && req_wide) |-> $countones(seg_en) == 2); // R4
  AST_ONE_WAY_EN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ($onehot0({|seg_en[7:4], |seg_en[3:0]}))); // R4
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we)); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R7
  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ready |-> (req_valid && !mem_req)); // R9
endmodule

bind dual_width_dcache dwc_checker #(.ADDR_W(ADDR_W)) u_dwc_checker (
  .clk, .rst_n, .req_valid, .req_wide, .req_addr, .resp_ready, .resp_err,
  .seg_en, .mem_req, .mem_we, .mem_addr, .mem_ack
);

// File: tb/dual_width_dcache_bench.sv
module dual_width_dcache_bench;
  localparam int ADDR_W = 16;
  localparam int NLINES = 1 << (ADDR_W - 3);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_wide = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic resp_ready, resp_err, mem_req, mem_we;
  logic [31:0] resp_rdata;
  logic [7:0] seg_en;
  logic [ADDR_W-4:0] mem_addr;
  logic [63:0] mem_wline;
  logic [63:0] mem_rline = '0;
  logic mem_ack = 0;

  always #4 clk = ~clk;

  dual_width_dcache #(.ADDR_W(ADDR_W), .SETS(16)) u_dual_width_dcache (
    .clk, .rst_n, .req_valid, .req_write, .req_wide, .req_addr, .req_wdata,
    .resp_ready, .resp_err, .resp_rdata, .seg_en, .mem_req, .mem_we,
    .mem_addr, .mem_wline, .mem_rline, .mem_ack
  );

  int total = 0, bad = 0;
  logic [63:0] bm [NLINES];
  logic [63:0] shadow [NLINES];
  int fill_cnt = 0, wb_cnt = 0, wb_line = -1;
  logic [63:0] wb_data = '0;
  int mt [16][2];
  bit mv [16][2];
  bit md [16][2];
  bit ml [16];

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // backing memory: acknowledges two cycles after a request
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        repeat (2) @(negedge clk);
        if (mem_we) begin
          bm[int'(mem_addr)] = mem_wline;
          wb_cnt++;
          wb_line = int'(mem_addr);
          wb_data = mem_wline;
        end else begin
          mem_rline = bm[int'(mem_addr)];
          fill_cnt++;
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic access(input bit wide, input bit wr, input int addr, input logic [31:0] wd);
    int s, t, off, line, w, v, f0, b0, waits, hk;
    bit mis, hit, expwb;
    logic [63:0] sh, expwd, exp_en;
    logic [31:0] exp_rd;
    s = (addr >> 3) & 15; t = addr >> 7; off = addr & 7; line = addr >> 3;
    mis = wide ? ((off % 4) != 0) : ((off % 2) != 0);
    hit = 0; w = 0; expwb = 0; expwd = 0; v = 0;
    for (int i = 0; i < 2; i++) if (mv[s][i] && mt[s][i] == t) begin hit = 1; w = i; end
    if (!mis && !hit) begin
      v = !mv[s][0] ? 0 : (!mv[s][1] ? 1 : int'(ml[s]));
      expwb = mv[s][v] && md[s][v];
      expwd = shadow[mt[s][v] * 16 + s];
      w = v;
    end
    f0 = fill_cnt; b0 = wb_cnt;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_wide = wide; req_addr = addr[ADDR_W-1:0]; req_wdata = wd;
    #1;
    waits = 0;
    while (!resp_ready) begin @(negedge clk); #1; waits++; end
    sh = shadow[line];
    hk = off / 2;
    exp_rd = wide ? ((off >= 4) ? sh[63:32] : sh[31:0]) : {16'h0, 16'(sh >> (16 * hk))};
    if (mis) exp_en = 0;
    else if (wide) exp_en = 64'(2'b11) << (4 * w + 2 * (off / 4));
    else exp_en = 64'(1) << (4 * w + hk);
    chk(resp_err == mis, "R3 error flag", resp_err, mis);
    chk(seg_en == exp_en[7:0], "R4 segment enables", seg_en, exp_en);
    if (!mis && !wr) chk(resp_rdata == exp_rd, "R1 load data", resp_rdata, exp_rd);
    chk(fill_cnt - f0 == ((mis || hit) ? 0 : 1), "R9 fill count", fill_cnt - f0, (mis || hit) ? 0 : 1);
    chk(wb_cnt - b0 == (expwb ? 1 : 0), "R6 write-back count", wb_cnt - b0, expwb);
    if (mis || hit) chk(waits == 0, "R9 same-cycle completion", waits, 0);
    if (expwb) begin
      chk(wb_data == expwd, "R6 write-back data", wb_data, expwd);
      chk(wb_line == mt[s][v] * 16 + s, "R6 write-back address", wb_line, mt[s][v] * 16 + s);
    end
    @(negedge clk);
    req_valid = 0;
    if (!mis) begin
      if (!hit) begin mt[s][w] = t; mv[s][w] = 1; md[s][w] = 0; end
      ml[s] = (w == 0);
      if (wr) begin
        md[s][w] = 1;
        if (wide) begin
          if (off >= 4) shadow[line][63:32] = wd; else shadow[line][31:0] = wd;
        end else begin
          for (int k = 0; k < 4; k++) if (k == hk) shadow[line][16*k +: 16] = wd[15:0];
        end
      end
    end
  endtask

  initial begin
    for (int i = 0; i < NLINES; i++) begin
      bm[i] = {32'(i) * 32'h9E3779B1, 32'(i) ^ 32'h5A5A0000};
      shadow[i] = bm[i];
    end
    for (int s = 0; s < 16; s++) begin
      ml[s] = 0;
      for (int w = 0; w < 2; w++) begin mv[s][w] = 0; md[s][w] = 0; mt[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    chk(resp_ready == 0, "R8 ready low in reset", resp_ready, 0);
    rst_n = 1;
    @(negedge clk);
    chk(mem_req == 0, "R8 no traffic after reset", mem_req, 0);
    chk(seg_en == 0, "R8 no enables after reset", seg_en, 0);
    // first access must miss: checked inside by fill count (R8)
    access(1'b1, 1'b0, 0, 0);
    // directed LRU case in set 5 (R5): A, B, A, then C evicts B
    access(0, 1, (1 << 7) | (5 << 3) | 2, 32'h0000BEEF);
    access(0, 0, (2 << 7) | (5 << 3), 0);
    access(0, 0, (1 << 7) | (5 << 3) | 2, 0);
    access(1, 0, (3 << 7) | (5 << 3) | 4, 0);
    access(0, 0, (1 << 7) | (5 << 3) | 2, 0);
    // sweep: every set, three tags, every offset, both widths, loads and stores (R1 R2 R3 R4 R5 R6)
    for (int rep = 0; rep < 2; rep++)
      for (int t = 0; t < 3; t++)
        for (int s = 0; s < 16; s++)
          for (int off = 0; off < 8; off++)
            for (int wide = 0; wide < 2; wide++)
              for (int wr = 1; wr >= 0; wr--)
                access(wide[0], wr[0], (((t + rep) % 3) << 7) | (s << 3) | off,
                       32'((rep * 4099 + t * 257 + s * 31 + off * 7 + wide) * 32'h01000193));
    // R7: all transfers above completed one line per acknowledge; final read-back of every line
    for (int t = 0; t < 3; t++)
      for (int s = 0; s < 16; s++)
        for (int off = 0; off < 8; off += 4) access(1, 0, (t << 7) | (s << 3) | off, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule